// File: doc/BRIEF.md
# Switch-State Word Writer with Programmable Stall

This block sits on a processor's write path at one memory-mapped location. Each accepted 24-bit word is split three ways. The low twelve bits are switch settings for analog boards. The next four bits select the target board. The top byte is a delay code. The block drives the switch settings and the board select together onto a 16-bit bus. It then pulses a latch strobe in the middle of a two-cycle valid window, and holds the processor off for the number of cycles the delay code gives.

The delay code has two ranges, chosen by its top bit. The seven lower bits count either single 20 ns cycles or 160 ns steps (eight cycles), and a fixed 80 ns (four cycles) is added in both ranges. The stall therefore runs from 4 to 1020 cycles at a 50 MHz design clock.

Board select value 0xF does not name an analog board. It is reserved for a separate A/D readout sequencer. Such a word leaves the switch bus untouched and raises no strobe. Instead the block issues a one-cycle start pulse with the twelve low bits attached. The stall still applies to these words.

Top module: `ssw_writer`

## Requirements
- R1: After reset, ready is 1, the switch bus is 0x0000, and the strobe, the A/D start pulse and the A/D argument are all 0.
- R2: A word is accepted on a rising edge where wr_en and ready are both 1. If its bits 15:12 are not 0xF, bits 15:0 appear on the switch bus from the next cycle on: bits 11:0 are the switch settings and bits 15:12 the board select. The bus holds that value until the next accepted switch word.
- R3: For an accepted switch word, the strobe is low in the first cycle of the valid window and high for exactly one cycle in the second. The bus is stable while the strobe is high.
- R4: When bit 23 of the accepted word is 0, ready is low for exactly v + 4 cycles, starting the cycle after acceptance, where v is bits 22:16.
- R5: When bit 23 of the accepted word is 1, ready is low for exactly 8*v + 4 cycles, where v is bits 22:16.
- R6: An accepted word whose bits 15:12 are 0xF leaves the switch bus unchanged and raises no strobe. It raises the A/D start pulse for exactly the first cycle after acceptance, with bits 11:0 on the A/D argument, and it stalls by the same rule as R4/R5.
- R7: A write presented while ready is 0 is ignored. The bus, the strobe, the A/D outputs and the length of the stall in progress are unaffected.
- R8: A write presented in the first cycle that ready is back at 1 is accepted at once, with no dead cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Design clock (50 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Processor write enable for the mapped location |
| wr_data | input | 24 | Word: [11:0] switches, [15:12] board select, [22:16] delay steps, [23] coarse range |
| ready | output | 1 | High when a write can be accepted; low during the stall |
| ss_bus | output | 16 | Switch-state bus: board select in [15:12], switches in [11:0] |
| ss_strobe | output | 1 | Latch strobe, high in the second cycle of the valid window |
| adc_start | output | 1 | One-cycle start pulse to the A/D readout sequencer |
| adc_arg | output | 12 | Low twelve bits of the last word diverted to the A/D sequencer |

## Verification
Take the rising edge that accepts a word as edge 0. The bus, ready = 0 and the A/D start pulse are due in the cycle after edge 0. The strobe is due in the cycle after edge 1. Ready returns in the cycle after edge D, where D is the decoded delay. The bench drives inputs and samples outputs on falling edges only, so each result is read in the middle of the cycle in which it is due. The bench counts low-ready samples from the first cycle after acceptance and compares the count with D computed from the delay code. At every sample inside the stall it also checks that the bus and the strobe still show the expected values, including while a write is held against ready = 0.

// File: rtl/ssw_pkg.sv
package ssw_pkg;

  // Destination of an accepted word
  typedef enum logic [0:0] {
    WK_SWITCH = 1'b0,
    WK_ADC    = 1'b1
  } word_kind_e;

  // Default geometry shared by the block and its checker
  localparam int unsigned SSW_SW_BITS      = 12;
  localparam int unsigned SSW_SEL_BITS     = 4;
  localparam int unsigned SSW_DLY_BITS     = 8;
  localparam int unsigned SSW_COARSE_SHIFT = 3;
  localparam int unsigned SSW_BASE_CYC     = 4;

endpackage

// File: rtl/ssw_rst_sync.sv
module ssw_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = 1'b1;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/ssw_delay_decode.sv
module ssw_delay_decode #(
  parameter int unsigned DLY_BITS     = 8,
  parameter int unsigned COARSE_SHIFT = 3,
  parameter int unsigned BASE_CYC     = 4,
  parameter int unsigned CNT_W        = 10
) (
  input  logic [DLY_BITS-1:0] code,
  output logic [CNT_W-1:0]    stall_cycles
);

  localparam int unsigned STEP_W = DLY_BITS - 1;

  logic              coarse_range;
  logic [STEP_W-1:0] step_count;
  logic [CNT_W-1:0]  scaled;

  assign coarse_range = code[DLY_BITS-1];
  assign step_count   = code[STEP_W-1:0];

  always_comb begin
    if (coarse_range) scaled = CNT_W'(step_count) << COARSE_SHIFT;
    else              scaled = CNT_W'(step_count);
    stall_cycles = scaled + CNT_W'(BASE_CYC);
  end

endmodule

// File: rtl/ssw_stall_counter.sv
module ssw_stall_counter #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] stall_cycles,
  output logic             busy
);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // Next-state: load on start, count down while busy, release at zero
  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = stall_cycles - CNT_W'(1);
      cnt_en = 1'b1;
    end else if (busy_q) begin
      cnt_en = 1'b1;
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign busy = busy_q;

endmodule

// File: rtl/ssw_bus_driver.sv
module ssw_bus_driver
  import ssw_pkg::*;
#(
  parameter int unsigned SW_BITS  = 12,
  parameter int unsigned SEL_BITS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        accept,
  input  logic [SW_BITS+SEL_BITS-1:0] word_lo,
  output logic [SW_BITS+SEL_BITS-1:0] ss_bus,
  output logic                        ss_strobe,
  output logic                        adc_start,
  output logic [SW_BITS-1:0]          adc_arg
);

  localparam int unsigned BUS_W = SW_BITS + SEL_BITS;
  localparam logic [SEL_BITS-1:0] ADC_SEL = {SEL_BITS{1'b1}};

  word_kind_e         kind;
  logic [BUS_W-1:0]   bus_q, bus_d;
  logic               bus_en;
  logic               win_q, win_d;
  logic               stb_q, stb_d;
  logic               adc_q, adc_d;
  logic [SW_BITS-1:0] arg_q, arg_d;
  logic               arg_en;

  always_comb begin
    if (word_lo[BUS_W-1:SW_BITS] == ADC_SEL) kind = WK_ADC;
    else                                     kind = WK_SWITCH;
  end

  // Next-state: first window cycle follows acceptance, strobe in the second
  always_comb begin
    bus_d  = word_lo;
    arg_d  = word_lo[SW_BITS-1:0];
    bus_en = accept && (kind == WK_SWITCH);
    arg_en = accept && (kind == WK_ADC);
    win_d  = bus_en;
    stb_d  = win_q;
    adc_d  = arg_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q <= '0;
      win_q <= 1'b0;
      stb_q <= 1'b0;
      adc_q <= 1'b0;
      arg_q <= '0;
    end else begin
      if (bus_en) bus_q <= bus_d;
      if (arg_en) arg_q <= arg_d;
      win_q <= win_d;
      stb_q <= stb_d;
      adc_q <= adc_d;
    end
  end

  assign ss_bus    = bus_q;
  assign ss_strobe = stb_q;
  assign adc_start = adc_q;
  assign adc_arg   = arg_q;

endmodule

// File: rtl/ssw_writer.sv
module ssw_writer
  import ssw_pkg::*;
#(
  parameter int unsigned SW_BITS      = SSW_SW_BITS,
  parameter int unsigned SEL_BITS     = SSW_SEL_BITS,
  parameter int unsigned DLY_BITS     = SSW_DLY_BITS,
  parameter int unsigned COARSE_SHIFT = SSW_COARSE_SHIFT,
  parameter int unsigned BASE_CYC     = SSW_BASE_CYC,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en,
  input  logic [SW_BITS+SEL_BITS+DLY_BITS-1:0] wr_data,
  output logic                                 ready,
  output logic [SW_BITS+SEL_BITS-1:0]          ss_bus,
  output logic                                 ss_strobe,
  output logic                                 adc_start,
  output logic [SW_BITS-1:0]                   adc_arg
);

  localparam int unsigned BUS_W   = SW_BITS + SEL_BITS;
  localparam int unsigned WORD_W  = BUS_W + DLY_BITS;
  localparam int unsigned MAX_CYC = ((2 ** (DLY_BITS - 1)) - 1) * (2 ** COARSE_SHIFT) + BASE_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  logic             rst_n_int;
  logic             busy;
  logic             accept;
  logic [CNT_W-1:0] stall_cycles;

  ssw_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  assign accept = wr_en && !busy;
  assign ready  = !busy;

  ssw_delay_decode #(
    .DLY_BITS     (DLY_BITS),
    .COARSE_SHIFT (COARSE_SHIFT),
    .BASE_CYC     (BASE_CYC),
    .CNT_W        (CNT_W)
  ) u_decode (
    .code         (wr_data[WORD_W-1:BUS_W]),
    .stall_cycles (stall_cycles)
  );

  ssw_stall_counter #(.CNT_W(CNT_W)) u_stall (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .start        (accept),
    .stall_cycles (stall_cycles),
    .busy         (busy)
  );

  ssw_bus_driver #(
    .SW_BITS  (SW_BITS),
    .SEL_BITS (SEL_BITS)
  ) u_bus (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .accept    (accept),
    .word_lo   (wr_data[BUS_W-1:0]),
    .ss_bus    (ss_bus),
    .ss_strobe (ss_strobe),
    .adc_start (adc_start),
    .adc_arg   (adc_arg)
  );

endmodule

// File: rtl/ssw_writer_chk.sv
module ssw_writer_chk #(
  parameter int unsigned SW_BITS  = 12,
  parameter int unsigned SEL_BITS = 4,
  parameter int unsigned DLY_BITS = 8
) (
  input logic                                 clk,
  input logic                                 rst_n,
  input logic                                 wr_en,
  input logic [SW_BITS+SEL_BITS+DLY_BITS-1:0] wr_data,
  input logic                                 ready,
  input logic [SW_BITS+SEL_BITS-1:0]          ss_bus,
  input logic                                 ss_strobe,
  input logic                                 adc_start
);

  localparam int unsigned BUS_W = SW_BITS + SEL_BITS;

  logic taken;
  logic to_adc;
  assign taken  = wr_en && ready;
  assign to_adc = (wr_data[BUS_W-1:SW_BITS] == {SEL_BITS{1'b1}});

  // R4
  stall_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> !ready);

  // R2
  bus_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && !to_adc) |=> (ss_bus == $past(wr_data[BUS_W-1:0])));

  // R3
  strobe_position_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ss_strobe |-> (!ready && $stable(ss_bus) && !$past(ss_strobe)));

  // R3
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ss_strobe |=> !ss_strobe);

  // R6
  adc_divert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && to_adc) |=> (adc_start && !ss_strobe && $stable(ss_bus)));

  // R7
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ready) |=> ($stable(ss_bus) && !adc_start));

endmodule

bind ssw_writer ssw_writer_chk #(
  .SW_BITS  (SW_BITS),
  .SEL_BITS (SEL_BITS),
  .DLY_BITS (DLY_BITS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .ready     (ready),
  .ss_bus    (ss_bus),
  .ss_strobe (ss_strobe),
  .adc_start (adc_start)
);

// File: tb/tb_ssw_writer.sv
`timescale 1ns/1ps
module tb_ssw_writer;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [23:0] wr_data;
  logic        ready;
  logic [15:0] ss_bus;
  logic        ss_strobe;
  logic        adc_start;
  logic [11:0] adc_arg;

  int n_cmp;
  int n_bad;
  logic [15:0] exp_bus;

  ssw_writer dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .ready     (ready),
    .ss_bus    (ss_bus),
    .ss_strobe (ss_strobe),
    .adc_start (adc_start),
    .adc_arg   (adc_arg)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int exp_stall(input logic [23:0] w);
    int v;
    v = int'(w[22:16]);
    return w[23] ? (8 * v + 4) : (v + 4);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // Drive one write at a falling edge with ready high; follow it to the end of its stall
  task automatic do_write(input logic [23:0] w, input bit poke, input string tag);
    bit is_adc;
    int want;
    int low_cnt;
    logic [23:0] junk;
    is_adc = (w[15:12] == 4'hF);
    want   = exp_stall(w);
    chk(ready == 1'b1, {tag, " ready before write"}, ready, 1);
    wr_en   = 1'b1;
    wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
    if (is_adc) begin
      chk(adc_start == 1'b1, "R6 start pulse", adc_start, 1);
      chk(adc_arg == w[11:0], "R6 argument", adc_arg, w[11:0]);
      chk(ss_bus == exp_bus, "R6 bus untouched", ss_bus, exp_bus);
    end else begin
      exp_bus = w[15:0];
      chk(ss_bus == exp_bus, {tag, " bus value"}, ss_bus, exp_bus);
      chk(adc_start == 1'b0, "R2 no A/D start", adc_start, 0);
    end
    chk(ss_strobe == 1'b0, "R3 strobe low in first window cycle", ss_strobe, 0);
    chk(ready == 1'b0, "R4 stall begins", ready, 0);
    low_cnt = 1;
    if (poke) begin
      junk = $urandom;
      wr_en   = 1'b1;
      wr_data = junk;
    end
    @(negedge clk);
    wr_en = 1'b0;
    if (!ready) low_cnt++;
    chk(ss_strobe == !is_adc, is_adc ? "R6 no strobe" : "R3 strobe high in second cycle",
        ss_strobe, !is_adc);
    chk(adc_start == 1'b0, "R6 pulse one cycle", adc_start, 0);
    chk(ss_bus == exp_bus, poke ? "R7 bus holds under busy write" : "R2 bus holds",
        ss_bus, exp_bus);
    forever begin
      @(negedge clk);
      if (ready) break;
      low_cnt++;
      if (ss_strobe !== 1'b0 || ss_bus !== exp_bus || adc_start !== 1'b0)
        chk(1'b0, "R7 outputs quiet during stall", {ss_strobe, adc_start, ss_bus}, {2'b00, exp_bus});
    end
    chk(low_cnt == want, w[23] ? (poke ? "R7/R5 stall length" : "R5 stall length")
                               : (poke ? "R7/R4 stall length" : "R4 stall length"),
        low_cnt, want);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin : main
    logic [23:0] w;
    int seed;
    n_cmp   = 0;
    n_bad   = 0;
    exp_bus = '0;
    wr_en   = 1'b0;
    wr_data = '0;
    rst_n   = 1'b0;
    seed    = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(ready == 1'b1, "R1 ready", ready, 1);
    chk(ss_bus == 16'h0, "R1 bus", ss_bus, 0);
    chk(ss_strobe == 1'b0, "R1 strobe", ss_strobe, 0);
    chk(adc_start == 1'b0, "R1 adc_start", adc_start, 0);
    chk(adc_arg == 12'h0, "R1 adc_arg", adc_arg, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ready == 1'b1 && ss_bus == 16'h0, "R1 after release", {ready, ss_bus}, 17'h10000);

    // Directed corners
    do_write({1'b0, 7'd0,   4'h3, 12'hA5C}, 1'b0, "R2");       // shortest fine: 4
    do_write({1'b0, 7'd127, 4'h0, 12'h001}, 1'b0, "R8");       // longest fine: 131, back-to-back
    do_write({1'b1, 7'd0,   4'hE, 12'hFFF}, 1'b0, "R8");       // coarse zero: 4, top valid board
    do_write({1'b1, 7'd127, 4'h7, 12'h3C3}, 1'b1, "R2");       // longest coarse: 1020
    do_write({1'b0, 7'd5,   4'hF, 12'h9AB}, 1'b1, "R6");       // A/D diversion, fine
    do_write({1'b1, 7'd3,   4'hF, 12'h123}, 1'b0, "R6");       // A/D diversion, coarse
    do_write({1'b0, 7'd2,   4'h1, 12'h800}, 1'b1, "R8");       // after diversion

    // Random mix
    for (int i = 0; i < 60; i++) begin
      w = $urandom;
      if (w[23]) w[22:16] = 7'($urandom_range(0, 31));
      if ($urandom_range(0, 5) == 0) w[15:12] = 4'hF;
      do_write(w, 1'($urandom_range(0, 1)), "R2");
      if ($urandom_range(0, 2) == 0) repeat ($urandom_range(1, 3)) @(negedge clk);
    end

    summary();
    $finish;
  end

endmodule